// File: doc/BRIEF.md
# Passive Serial Configuration Loader

This block sits on the host side of a passive serial configuration link and loads a bitstream into a programmable target device. It owns the handshake lines towards the target. It pulls the program line low for a minimum time and then releases it. It waits until the target's status line has been seen low and then released. After that it shifts the bitstream out one bit per generated serial clock period. When the last bit has gone out, it keeps clocking until the target reports a successful load and, if enabled, until the target's initialization flag drops.

Bitstream bytes enter on a valid/ready port, one byte per accepted transfer. A flag marks the final byte. The serial clock is a parameterized integer divide of the system clock, and it pauses, held low, while the loader waits for the next byte. Three status outputs report progress: busy, done (the target is in user mode) and err (status wait timed out, load aborted by the target, or too many trailing clocks). The three inputs from the target are asynchronous and pass through synchronizer stages. A new load can be started from idle, after an error, or from user mode to reconfigure the target.

Top module: `ps_cfg_loader`

## Requirements
- R1: A `start` pulse seen while `busy` is low drives `cfg_prog_n` low for exactly PROG_LOW system cycles, beginning the cycle after `start`, and then releases it. A `start` while `busy` is high has no effect.
- R2: After releasing `cfg_prog_n`, the loader clocks no data until the synchronized `cfg_stat` has been seen low and then high. If this does not happen within STAT_WAIT cycles, `err` is set and the loader returns to idle.
- R3: `in_ready` is high only while loading data with the bit shifter empty. A byte is taken in a cycle with `in_valid` and `in_ready` both high.
- R4: Bits leave on `cfg_dat` least significant bit first, byte after byte, one bit per `cfg_clk` period. `cfg_dat` changes only together with a falling `cfg_clk` or while `cfg_clk` is low, and it is stable while `cfg_clk` is high.
- R5: Each `cfg_clk` half period lasts CLK_DIV system cycles. `cfg_clk` is held low while idle, while waiting for a byte and in user mode.
- R6: `cfg_dat_oe` is low before the first bit of a load, while waiting for a byte, and after the last bit until user mode is reached.
- R7: After the final bit, `cfg_clk` keeps toggling until the synchronized `cfg_done` is high and (when USE_INIT is 1) the synchronized `cfg_init` is low. `done` then goes high.
- R8: If a further rising `cfg_clk` edge would be needed after TAIL_MAX trailing rising edges, `err` is set instead, and `done` stays low.
- R9: If the synchronized `cfg_stat` is low while data is being loaded or trailing clocks are running, the load aborts: `err` is set, `busy` drops, and `cfg_clk` and `cfg_dat_oe` return low.
- R10: In user mode `cfg_clk` is low, `cfg_dat_oe` is high with `cfg_dat` low, and `cfg_prog_n` is high.
- R11: `busy` is high from the cycle after an accepted `start` until user mode or an error is reached. `err` and `done` clear on an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins a load or reconfiguration when not busy |
| in_valid | input | 1 | Bitstream byte valid |
| in_data | input | BYTE_W | Bitstream byte, least significant bit sent first |
| in_last | input | 1 | Marks the final byte of the bitstream |
| in_ready | output | 1 | Loader can take a byte |
| cfg_prog_n | output | 1 | Program request to the target, low requests configuration |
| cfg_clk | output | 1 | Serial configuration clock |
| cfg_dat | output | 1 | Serial configuration data |
| cfg_dat_oe | output | 1 | Drive enable for `cfg_dat`; when low the line is left to its pull-up |
| cfg_stat | input | 1 | Target status, low while the target is not ready or has failed |
| cfg_done | input | 1 | Target reports a complete configuration |
| cfg_init | input | 1 | Target initialization flag, low once user mode is entered |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Target is configured and in user mode |
| err | output | 1 | Last load failed; cleared by the next start |

## Verification
The bench builds the loader with CLK_DIV=2, PROG_LOW=4, STAT_WAIT=40, TAIL_MAX=6, USE_INIT=1 and two synchronizer stages. With these values the status timeout, the trailing clock overrun and an abort in the middle of a byte all happen within a few dozen cycles. A target model whose release delay and done/init thresholds can be set in the bench makes each of these cases happen. The short divide keeps every clock half period and the data-on-falling-edge rule visible cycle by cycle. Because initialization ends two rising edges after done, the bench shows that the loader waits for both conditions.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

  typedef enum logic [2:0] {
    LD_IDLE  = 3'd0,
    LD_PROG  = 3'd1,
    LD_WSTAT = 3'd2,
    LD_XFER  = 3'd3,
    LD_TAIL  = 3'd4,
    LD_USER  = 3'd5
  } ld_state_e;

endpackage

// File: rtl/ps_cfg_sync.sv
module ps_cfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= '0;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/ps_cfg_tick.sv
module ps_cfg_tick #(
  parameter int unsigned DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign tick = en && (cnt_q == CW'(DIV - 1));

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ps_cfg_shift.sv
module ps_cfg_shift #(
  parameter int unsigned BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          allow,
  input  logic          in_valid,
  input  logic [BW-1:0] in_data,
  input  logic          in_last,
  output logic          in_ready,
  input  logic          adv,
  output logic          bit_o,
  output logic          full,
  output logic          final_o
);

  localparam int unsigned CW = $clog2(BW + 1);

  logic [BW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last_q, last_d;
  logic          take;

  assign full     = (cnt_q != '0);
  assign in_ready = allow && !full;
  assign take     = in_ready && in_valid;
  assign bit_o    = sh_q[0];
  assign final_o  = last_q && (cnt_q == CW'(1));

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    if (clr) begin
      cnt_d  = '0;
      last_d = 1'b0;
    end else if (take) begin
      sh_d   = in_data;
      cnt_d  = CW'(BW);
      last_d = in_last;
    end else if (adv && full) begin
      sh_d  = {1'b0, sh_q[BW-1:1]};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/ps_cfg_loader.sv
module ps_cfg_loader
  import ps_cfg_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 4,
  parameter int unsigned PROG_LOW    = 200,
  parameter int unsigned STAT_WAIT   = 10000000,
  parameter int unsigned TAIL_MAX    = 1024,
  parameter int unsigned USE_INIT    = 1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              cfg_prog_n,
  output logic              cfg_clk,
  output logic              cfg_dat,
  output logic              cfg_dat_oe,
  input  logic              cfg_stat,
  input  logic              cfg_done,
  input  logic              cfg_init,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int unsigned T_A  = (PROG_LOW > STAT_WAIT) ? PROG_LOW : STAT_WAIT;
  localparam int unsigned T_B  = (T_A > TAIL_MAX) ? T_A : TAIL_MAX;
  localparam int unsigned TW   = $clog2(T_B + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_i = rst_pipe_q[1];

  // synchronized target lines
  logic [2:0] tgt_raw, tgt_s;
  logic       stat_s, done_s, init_s;

  assign tgt_raw = {cfg_init, cfg_done, cfg_stat};

  ps_cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i),
    .d     (tgt_raw),
    .q     (tgt_s)
  );

  assign stat_s = tgt_s[0];
  assign done_s = tgt_s[1];
  assign init_s = tgt_s[2];

  // state
  ld_state_e st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic sclk_q, sclk_d;
  logic err_q, err_d;
  logic done_q, done_d;
  logic seen_q, seen_d;

  // shifter and clock divider links
  logic sh_full, sh_bit, sh_final;
  logic tick, tick_en, rise, fall, adv, fin_ok;
  logic in_xfer;

  assign in_xfer = (st_q == LD_XFER);
  assign tick_en = (in_xfer && sh_full) || (st_q == LD_TAIL);
  assign rise    = tick && !sclk_q;
  assign fall    = tick && sclk_q;
  assign adv     = in_xfer && fall && stat_s;
  assign fin_ok  = done_s && ((USE_INIT == 0) || !init_s);

  ps_cfg_tick #(.DIV(CLK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_i),
    .en    (tick_en),
    .tick  (tick)
  );

  ps_cfg_shift #(.BW(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_i),
    .clr      (!in_xfer),
    .allow    (in_xfer),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_last  (in_last),
    .in_ready (in_ready),
    .adv      (adv),
    .bit_o    (sh_bit),
    .full     (sh_full),
    .final_o  (sh_final)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    sclk_d = sclk_q;
    err_d  = err_q;
    done_d = done_q;
    seen_d = seen_q;
    unique case (st_q)
      LD_IDLE, LD_USER: begin
        sclk_d = 1'b0;
        if (start) begin
          st_d   = LD_PROG;
          tmr_d  = '0;
          err_d  = 1'b0;
          done_d = 1'b0;
          seen_d = 1'b0;
        end
      end
      LD_PROG: begin
        if (!stat_s) seen_d = 1'b1;
        if (tmr_q == TW'(PROG_LOW - 1)) begin
          st_d  = LD_WSTAT;
          tmr_d = '0;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      LD_WSTAT: begin
        if (!stat_s) seen_d = 1'b1;
        if (seen_q && stat_s) begin
          st_d  = LD_XFER;
          tmr_d = '0;
        end else if (tmr_q == TW'(STAT_WAIT - 1)) begin
          st_d  = LD_IDLE;
          err_d = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      LD_XFER: begin
        if (!stat_s) begin
          st_d   = LD_IDLE;
          err_d  = 1'b1;
          sclk_d = 1'b0;
        end else if (rise) begin
          sclk_d = 1'b1;
        end else if (fall) begin
          sclk_d = 1'b0;
          if (sh_final) begin
            st_d  = LD_TAIL;
            tmr_d = '0;
          end
        end
      end
      LD_TAIL: begin
        if (!stat_s) begin
          st_d   = LD_IDLE;
          err_d  = 1'b1;
          sclk_d = 1'b0;
        end else if (fin_ok) begin
          st_d   = LD_USER;
          done_d = 1'b1;
          sclk_d = 1'b0;
        end else if (rise) begin
          if (tmr_q == TW'(TAIL_MAX)) begin
            st_d   = LD_IDLE;
            err_d  = 1'b1;
            sclk_d = 1'b0;
          end else begin
            tmr_d  = tmr_q + 1'b1;
            sclk_d = 1'b1;
          end
        end else if (fall) begin
          sclk_d = 1'b0;
        end
      end
      default: begin
        st_d   = LD_IDLE;
        sclk_d = 1'b0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q   <= LD_IDLE;
      tmr_q  <= '0;
      sclk_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      sclk_q <= sclk_d;
      err_q  <= err_d;
      done_q <= done_d;
      seen_q <= seen_d;
    end
  end

  // outputs
  assign cfg_prog_n = (st_q != LD_PROG);
  assign cfg_clk    = sclk_q;
  assign cfg_dat    = (in_xfer && sh_full) ? sh_bit : 1'b0;
  assign cfg_dat_oe = (in_xfer && sh_full) || (st_q == LD_USER);
  assign busy       = (st_q == LD_PROG) || (st_q == LD_WSTAT) ||
                      (st_q == LD_XFER) || (st_q == LD_TAIL);
  assign done       = done_q;
  assign err        = err_q;

endmodule

// File: rtl/ps_cfg_loader_chk.sv
module ps_cfg_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic cfg_prog_n,
  input logic cfg_clk,
  input logic cfg_dat,
  input logic cfg_dat_oe,
  input logic busy,
  input logic done,
  input logic err
);

  // R1: program request only while a load is in progress, with the clock low
  p_prog_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> (busy && !cfg_clk));

  // R3: a byte is only accepted when no bit is being driven
  p_ready_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !cfg_dat_oe));

  // R4: data stays put while the serial clock is high
  p_dat_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_clk && $past(cfg_clk) && cfg_dat_oe && $past(cfg_dat_oe)) |-> $stable(cfg_dat));

  // R5: clock parked low whenever no load runs
  p_clk_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cfg_clk);

  // R8: success and failure never reported together
  p_done_xor_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R9: an error leaves the loader idle
  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy);

  // R10: user mode line levels
  p_user_lines_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cfg_clk && cfg_dat_oe && !cfg_dat && cfg_prog_n && !busy));

endmodule

bind ps_cfg_loader ps_cfg_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .cfg_prog_n (cfg_prog_n),
  .cfg_clk    (cfg_clk),
  .cfg_dat    (cfg_dat),
  .cfg_dat_oe (cfg_dat_oe),
  .busy       (busy),
  .done       (done),
  .err        (err)
);

// File: tb/ps_cfg_loader_tb.sv
`timescale 1ns/1ps
module ps_cfg_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 2;
  localparam int PLOW  = 4;
  localparam int SWAIT = 40;
  localparam int TMAX  = 6;
  localparam int NSYNC = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic start, in_valid, in_last;
  logic [7:0] in_data;
  logic in_ready, cfg_prog_n, cfg_clk, cfg_dat, cfg_dat_oe;
  logic cfg_stat, cfg_done, cfg_init;
  logic busy, done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  ps_cfg_loader #(
    .CLK_DIV(DIV), .PROG_LOW(PLOW), .STAT_WAIT(SWAIT), .TAIL_MAX(TMAX),
    .USE_INIT(1), .SYNC_STAGES(NSYNC), .BYTE_W(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .cfg_prog_n(cfg_prog_n), .cfg_clk(cfg_clk), .cfg_dat(cfg_dat),
    .cfg_dat_oe(cfg_dat_oe), .cfg_stat(cfg_stat), .cfg_done(cfg_done),
    .cfg_init(cfg_init), .busy(busy), .done(done), .err(err)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- target model ----------------
  int  tgt_rc, tgt_rel;
  int  stat_delay, need_done, need_init;
  logic force_low, tgt_prev_clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_rc <= 0; tgt_rel <= 0; cfg_stat <= 1'b0; tgt_prev_clk <= 1'b0;
    end else begin
      tgt_prev_clk <= cfg_clk;
      if (!cfg_prog_n) tgt_rc <= 0;
      else if (cfg_clk && !tgt_prev_clk) tgt_rc <= tgt_rc + 1;
      if (!cfg_prog_n) begin
        cfg_stat <= 1'b0; tgt_rel <= 0;
      end else if (force_low) begin
        cfg_stat <= 1'b0;
      end else if (!cfg_stat) begin
        if (tgt_rel >= stat_delay) cfg_stat <= 1'b1;
        else tgt_rel <= tgt_rel + 1;
      end
    end
  end

  assign cfg_done = (tgt_rc >= need_done);
  assign cfg_init = !cfg_prog_n || (tgt_rc < need_init);

  // ---------------- reference model ----------------
  int m_mode, m_tmr, m_divc;
  logic m_sclk, m_err, m_done, m_seen;
  logic [NSYNC-1:0] m_sp, m_dp, m_ip;
  int m_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_tmr = 0; m_divc = 0;
      m_sclk = 0; m_err = 0; m_done = 0; m_seen = 0;
      m_sp = '0; m_dp = '0; m_ip = '0;
      m_q.delete();
    end else begin
      logic s_st, s_dn, s_in, full, en, tick, rise, fall, load, fin, seen_old;
      s_st = m_sp[NSYNC-1]; s_dn = m_dp[NSYNC-1]; s_in = m_ip[NSYNC-1];
      m_sp = {m_sp[NSYNC-2:0], cfg_stat};
      m_dp = {m_dp[NSYNC-2:0], cfg_done};
      m_ip = {m_ip[NSYNC-2:0], cfg_init};
      full = (m_q.size() != 0);
      en   = (m_mode == 3 && full) || m_mode == 4;
      tick = en && (m_divc == DIV - 1);
      m_divc = (!en || tick) ? 0 : m_divc + 1;
      rise = tick && !m_sclk;
      fall = tick && m_sclk;
      load = (m_mode == 3) && !full && in_valid;
      fin  = s_dn && !s_in;
      seen_old = m_seen;
      case (m_mode)
        0, 5: begin
          m_sclk = 0;
          if (start) begin
            m_mode = 1; m_tmr = 0; m_err = 0; m_done = 0; m_seen = 0;
            m_q.delete();
          end
        end
        1: begin
          if (!s_st) m_seen = 1;
          if (m_tmr == PLOW - 1) begin m_mode = 2; m_tmr = 0; end
          else m_tmr++;
        end
        2: begin
          if (!s_st) m_seen = 1;
          if (seen_old && s_st) begin m_mode = 3; m_tmr = 0; end
          else if (m_tmr == SWAIT - 1) begin m_mode = 0; m_err = 1; end
          else m_tmr++;
        end
        3: begin
          if (!s_st) begin m_mode = 0; m_err = 1; m_sclk = 0; end
          else if (rise) m_sclk = 1;
          else if (fall) begin
            m_sclk = 0;
            if (m_q[0] >= 2) begin m_mode = 4; m_tmr = 0; end
            void'(m_q.pop_front());
          end
        end
        4: begin
          if (!s_st) begin m_mode = 0; m_err = 1; m_sclk = 0; end
          else if (fin) begin m_mode = 5; m_done = 1; m_sclk = 0; end
          else if (rise) begin
            if (m_tmr == TMAX) begin m_mode = 0; m_err = 1; m_sclk = 0; end
            else begin m_tmr++; m_sclk = 1; end
          end else if (fall) m_sclk = 0;
        end
        default: m_mode = 0;
      endcase
      if (load) begin
        for (int b = 0; b < 8; b++)
          m_q.push_back(int'(in_data[b]) + ((in_last && b == 7) ? 2 : 0));
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic live;
      live = (m_mode == 3) && (m_q.size() != 0);
      chk("R1 prog_n", cfg_prog_n, m_mode != 1);
      chk("R5 cfg_clk", cfg_clk, m_sclk);
      chk("R6 dat_oe", cfg_dat_oe, live || m_mode == 5);
      chk("R4 cfg_dat", cfg_dat, live ? logic'(m_q[0] & 1) : 1'b0);
      chk("R3 in_ready", in_ready, (m_mode == 3) && (m_q.size() == 0));
      chk("R11 busy", busy, m_mode >= 1 && m_mode <= 4);
      chk("R7 done", done, m_done);
      chk("R9 err", err, m_err);
    end
  end

  // bits seen by the target on rising clock edges
  logic cap[$];
  always @(posedge cfg_clk) if (cfg_dat_oe) cap.push_back(cfg_dat);

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=50000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- tasks ----------------
  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b, input logic l);
    int n;
    n = 0;
    @(negedge clk); in_valid = 1'b1; in_data = b; in_last = l;
    while (!in_ready && n < 500) begin @(negedge clk); n++; end
    if (n >= 500) chk("R3 byte accepted", 1'b0, 1'b1);
    @(negedge clk); in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    int n;
    n = 0;
    while (busy && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  logic exp_bits[$];
  logic [7:0] seq [3];

  initial begin
    rst_n = 1'b0; start = 0; in_valid = 0; in_last = 0; in_data = '0;
    force_low = 0; stat_delay = 5; need_done = 1000; need_init = 1000;
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(6);

    // reset state
    chk("R11 reset busy", busy, 1'b0);
    chk("R5 reset clk", cfg_clk, 1'b0);
    chk("R6 reset oe", cfg_dat_oe, 1'b0);
    chk("R1 reset prog_n", cfg_prog_n, 1'b1);

    // normal load of three bytes
    seq[0] = 8'hA5; seq[1] = 8'h3C; seq[2] = 8'h81;
    exp_bits.delete(); cap.delete();
    for (int i = 0; i < 3; i++)
      for (int b = 0; b < 8; b++) exp_bits.push_back(seq[i][b]);
    need_done = 26; need_init = 28;
    pulse_start();
    chk("R1 prog low after start", cfg_prog_n, 1'b0);
    chk("R2 no clock while programming", cfg_clk, 1'b0);
    feed(seq[0], 1'b0);
    pulse_start();                      // ignored while busy
    chk("R1 start ignored while busy", cfg_prog_n, 1'b1);
    idle_cycles(3);
    feed(seq[1], 1'b0);
    feed(seq[2], 1'b1);
    wait_idle(300);
    chk("R7 done after load", done, 1'b1);
    chk("R8 no error on good load", err, 1'b0);
    chk("R4 bit count", cap.size() == 24, 1'b1);
    for (int i = 0; i < 24 && i < cap.size(); i++)
      chk($sformatf("R4 bit %0d lsb first", i), cap[i], exp_bits[i]);
    idle_cycles(3);
    chk("R10 user clk low", cfg_clk, 1'b0);
    chk("R10 user data driven", cfg_dat_oe, 1'b1);
    chk("R10 user data low", cfg_dat, 1'b0);
    chk("R10 user prog high", cfg_prog_n, 1'b1);

    // reconfigure from user mode
    need_done = 9; need_init = 9;
    pulse_start();
    chk("R1 reconfig prog low", cfg_prog_n, 1'b0);
    chk("R11 done cleared by start", done, 1'b0);
    feed(8'h5A, 1'b1);
    wait_idle(300);
    chk("R7 done after reconfig", done, 1'b1);

    // status never released
    stat_delay = 1000;
    pulse_start();
    wait_idle(300);
    chk("R2 status timeout error", err, 1'b1);
    chk("R2 no done on timeout", done, 1'b0);
    stat_delay = 5;
    idle_cycles(4);

    // abort in the middle of a byte
    need_done = 1000; need_init = 1000;
    pulse_start();
    chk("R11 err cleared by start", err, 1'b0);
    feed(8'hC3, 1'b0);
    idle_cycles(5);
    force_low = 1'b1;
    idle_cycles(6);
    chk("R9 abort error", err, 1'b1);
    chk("R9 abort idle", busy, 1'b0);
    chk("R6 abort oe low", cfg_dat_oe, 1'b0);
    chk("R9 abort clk low", cfg_clk, 1'b0);
    force_low = 1'b0;
    idle_cycles(10);

    // trailing clock overrun
    pulse_start();
    feed(8'h0F, 1'b1);
    wait_idle(300);
    chk("R8 overrun error", err, 1'b1);
    chk("R8 overrun no done", done, 1'b0);

    idle_cycles(5);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule